// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the eight-bit status register of a serial flash slave and rules on every write-type command that the command decoder hands it. The decoder presents one command per strobe: an opcode, a target address for program and erase, and a data byte for a status write. The block answers one clock later with a single-cycle verdict that says whether the memory engine may run the request or must drop it. The verdict is based on the write-enable latch, a three-bit block-protect code, a lock bit paired with the write-protect pin, and an arming rule for status writes.

The address space is 512 KB in eight 64 KB blocks. The protect code covers the top eighth, the top quarter, the top half or the whole array. The busy flag comes straight from the program engine. The auto-increment flag is latched on the engine's rising edge and cleared by the block.

Top module: `flash_sr_guard`

## Requirements
- R1: `status_o` is {lock, aai, 0, bp[2:0], wel, busy}, with lock in bit 7 and busy in bit 0. Bit 5 always reads 0, and bit 0 follows `busy_in` in the same cycle.
- R2: While `rst_n` is low, and after it rises, `status_o` reads 0x1C (busy input low): protect code 111, lock, wel and aai 0. `verdict_valid` is low.
- R3: Protect code 000 locks nothing. Code 001 locks 0x70000 and up, 010 locks 0x60000 and up, 011 locks 0x40000 and up, and any code with bit 2 set locks the whole array.
- R4: A permitted status write loads `cmd_data[7]` into lock and `cmd_data[4:2]` into bp, and it clears wel. With `wp_pin` low and lock 1, the write is refused and changes nothing. With `wp_pin` high, all four bits can change, and lock can be cleared.
- R5: With `wp_pin` low and lock 0, one status write may set lock and change bp at the same time.
- R6: A status write is permitted only when the previous strobe was WREN or EWSR. Any other strobe in between, including code 0, disarms it.
- R7: WREN sets wel. WRDI, a permitted program or erase, a permitted status write, and a pulse on `aai_top` each clear it. The `aai_top` clear wins over a WREN in the same cycle.
- R8: A program (byte address) is refused when wel is 0 or the target lies in the locked region. So are a sector erase (address bits 18:12) and a block erase (bits 18:16). A refused request changes no status bit.
- R9: A chip erase is permitted only when wel is 1 and bp is 000.
- R10: The aai bit sets on a rising edge of `aai_in`. WRDI or `aai_top` clears both aai and wel.
- R11: Opcodes are 0 other, 1 WREN, 2 WRDI, 3 EWSR, 4 status write, 5 program, 6 sector erase, 7 block erase, 8 chip erase. A strobe with opcode 4 to 8 gives `verdict_valid` high for exactly the next cycle, with `verdict_allow` showing the ruling. Other opcodes give no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | ADDR_W (19) | Target byte address for program and erase |
| cmd_data | input | 8 | Data byte for a status write |
| wp_pin | input | 1 | Write-protect pin level, 1 = high |
| busy_in | input | 1 | Busy flag from the program engine |
| aai_in | input | 1 | Auto-increment mode flag from the program engine |
| aai_top | input | 1 | Pulse: auto-increment reached the top address |
| status_o | output | 8 | Status byte |
| wel_o | output | 1 | Write-enable latch |
| verdict_valid | output | 1 | Verdict strobe, one cycle after a write-type command |
| verdict_allow | output | 1 | 1 = request runs, 0 = request ignored |

## Verification
The reference model is compared on every clock, so a wrong internal state shows at the ports within one cycle of the strobe that exposes it. A wrong lock bit or protect code appears in `status_o` directly. It also flips the verdict of the next status write or the next program aimed near a region boundary. A stale arming flag stays hidden until the next status write, which then gets the wrong verdict. A wel error shows in `wel_o` at once and in every later program or erase verdict.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_WREN   = 4'd1,
    OP_WRDI   = 4'd2,
    OP_EWSR   = 4'd3,
    OP_WRSR   = 4'd4,
    OP_PROG   = 4'd5,
    OP_SERASE = 4'd6,
    OP_BERASE = 4'd7,
    OP_CERASE = 4'd8
  } fsg_op_e;

  localparam int unsigned SR_BUSY = 0;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_BP   = 2;
  localparam int unsigned SR_AAI  = 6;
  localparam int unsigned SR_LOCK = 7;
  localparam logic [7:0]  SR_WMASK = 8'h9C;
  localparam logic [7:0]  SR_RESET = 8'h1C;

  // First block index covered by a protect code; nblocks means none.
  function automatic int unsigned first_locked_block(logic [2:0] bp, int unsigned nblocks);
    if (bp[2])             return 0;
    else if (bp == 3'b011) return nblocks / 2;
    else if (bp == 3'b010) return nblocks - nblocks / 4;
    else if (bp == 3'b001) return nblocks - nblocks / 8;
    else                   return nblocks;
  endfunction

  function automatic logic is_verdict_op(logic [3:0] op);
    return (op == OP_WRSR) || (op == OP_PROG) || (op == OP_SERASE) ||
           (op == OP_BERASE) || (op == OP_CERASE);
  endfunction
endpackage

// File: rtl/fsg_arm.sv
module fsg_arm
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  output logic       armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_o <= 1'b0;
    else if (cmd_valid) armed_o <= (cmd_op == OP_WREN) || (cmd_op == OP_EWSR);
  end
endmodule

// File: rtl/fsg_judge.sv
module fsg_judge
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLK_LSB  = 16,
  parameter int unsigned SECT_LSB = 12
) (
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        bp,
  input  logic              lock,
  input  logic              wel,
  input  logic              wp_pin,
  input  logic              armed,
  output logic              verdict_req,
  output logic              allow
);
  localparam int unsigned NBLK = 1 << (ADDR_W - BLK_LSB);
  localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] target;
  logic [ADDR_W:0]   floor_addr;
  logic              locked;

  always_comb begin
    case (cmd_op)
      OP_SERASE: target = cmd_addr & SECT_MASK;
      OP_BERASE: target = cmd_addr & BLK_MASK;
      default:   target = cmd_addr;
    endcase
    floor_addr = (ADDR_W + 1)'(first_locked_block(bp, NBLK)) << BLK_LSB;
    locked     = {1'b0, target} >= floor_addr;
  end

  always_comb begin
    verdict_req = cmd_valid && is_verdict_op(cmd_op);
    case (cmd_op)
      OP_WRSR:                     allow = armed && (wp_pin || !lock);
      OP_PROG, OP_SERASE, OP_BERASE: allow = wel && !locked;
      OP_CERASE:                   allow = wel && (bp == 3'b000);
      default:                     allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsg_regs.sv
module fsg_regs
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       verdict_req,
  input  logic       allow,
  input  logic       aai_in,
  input  logic       aai_top,
  output logic [7:0] wr_bits,
  output logic       wel_q,
  output logic       aai_q,
  output logic       vv_q,
  output logic       va_q
);
  logic aai_d;
  logic granted, sr_load, wel_clr, wel_set, aai_rise, aai_clr;

  assign granted  = verdict_req && allow;
  assign sr_load  = granted && (cmd_op == OP_WRSR);
  assign wel_clr  = aai_top || granted || (cmd_valid && cmd_op == OP_WRDI);
  assign wel_set  = cmd_valid && (cmd_op == OP_WREN);
  assign aai_rise = aai_in && !aai_d;
  assign aai_clr  = aai_top || (cmd_valid && cmd_op == OP_WRDI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bits <= SR_RESET;
      wel_q   <= 1'b0;
      aai_q   <= 1'b0;
      aai_d   <= 1'b0;
      vv_q    <= 1'b0;
      va_q    <= 1'b0;
    end else begin
      vv_q  <= verdict_req;
      va_q  <= granted;
      aai_d <= aai_in;
      if (sr_load) wr_bits <= cmd_data & SR_WMASK;
      if (wel_clr)      wel_q <= 1'b0;
      else if (wel_set) wel_q <= 1'b1;
      if (aai_clr)       aai_q <= 1'b0;
      else if (aai_rise) aai_q <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLK_LSB  = 16,
  parameter int unsigned SECT_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_pin,
  input  logic              busy_in,
  input  logic              aai_in,
  input  logic              aai_top,
  output logic [7:0]        status_o,
  output logic              wel_o,
  output logic              verdict_valid,
  output logic              verdict_allow
);
  logic       armed;
  logic       verdict_req, allow;
  logic [7:0] wr_bits;
  logic       wel_q, aai_q;
  logic [2:0] bp;
  logic       lock;

  assign bp   = wr_bits[SR_BP +: 3];
  assign lock = wr_bits[SR_LOCK];

  fsg_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .armed_o(armed)
  );

  fsg_judge #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SECT_LSB(SECT_LSB)) u_judge (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .bp(bp), .lock(lock),
    .wel(wel_q), .wp_pin(wp_pin), .armed(armed), .verdict_req(verdict_req), .allow(allow)
  );

  fsg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .verdict_req(verdict_req), .allow(allow), .aai_in(aai_in), .aai_top(aai_top),
    .wr_bits(wr_bits), .wel_q(wel_q), .aai_q(aai_q), .vv_q(verdict_valid), .va_q(verdict_allow)
  );

  always_comb begin
    status_o          = wr_bits & SR_WMASK;
    status_o[SR_AAI]  = aai_q;
    status_o[SR_WEL]  = wel_q;
    status_o[SR_BUSY] = busy_in;
  end
  assign wel_o = wel_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       wp_pin,
  input logic       aai_top,
  input logic       armed,
  input logic [7:0] status_o,
  input logic       wel_o,
  input logic       verdict_valid,
  input logic       verdict_allow
);
  AST_LOCKED_SR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd4 && !wp_pin && status_o[7]
    |=> !verdict_allow && $stable(status_o[7]) && $stable(status_o[4:2])); // R4
  AST_LOCK_STICKY_WP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_pin && status_o[7] |=> status_o[7]); // R5
  AST_UNARMED_WRSR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd4 && !armed |=> verdict_valid && !verdict_allow); // R6
  AST_WREN_SETS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd1 && !aai_top |=> wel_o); // R7
  AST_NO_WRITE_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op >= 4'd5 && cmd_op <= 4'd8 && !wel_o
    |=> verdict_valid && !verdict_allow); // R8
  AST_CHIP_ERASE_NEEDS_CLEAR_BP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd8 && status_o[4:2] != 3'b000 |=> !verdict_allow); // R9
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd2 |=> !wel_o && !status_o[6]); // R10
  AST_NO_VERDICT_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op <= 4'd3 |=> !verdict_valid && !verdict_allow); // R11
endmodule

bind flash_sr_guard fsg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wp_pin(wp_pin),
  .aai_top(aai_top), .armed(armed), .status_o(status_o), .wel_o(wel_o),
  .verdict_valid(verdict_valid), .verdict_allow(verdict_allow)
);

// File: tb/tb_flash_sr_guard.sv
`timescale 1ns/1ps
module tb_flash_sr_guard;
  localparam int OTH = 0, WREN = 1, WRDI = 2, EWSR = 3, WRSR = 4,
                 PROG = 5, SE = 6, BE = 7, CE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        wp_pin = 1'b1, busy_in = 1'b0, aai_in = 1'b0, aai_top = 1'b0;
  logic [7:0]  status_o;
  logic        wel_o, verdict_valid, verdict_allow;

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R2";

  // reference model state
  int m_bp = 7, m_lock = 0, m_wel = 0, m_aai = 0, m_arm = 0, m_vv = 0, m_va = 0, m_aai_prev = 0;

  always #2.5 clk = ~clk;

  flash_sr_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .wp_pin(wp_pin), .busy_in(busy_in), .aai_in(aai_in), .aai_top(aai_top),
    .status_o(status_o), .wel_o(wel_o), .verdict_valid(verdict_valid), .verdict_allow(verdict_allow)
  );

  function automatic int lowest_locked(int bp);
    if (bp >= 4) return 0;
    case (bp)
      1: return 'h70000;
      2: return 'h60000;
      3: return 'h40000;
      default: return 'h80000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bp = 7; m_lock = 0; m_wel = 0; m_aai = 0; m_arm = 0; m_vv = 0; m_va = 0; m_aai_prev = 0;
    end else begin
      int op, a, ok, wel_n, aai_n;
      op = cmd_valid ? int'(cmd_op) : -1;
      a = int'(cmd_addr);
      ok = 0;
      if (op == WRSR) ok = m_arm && (wp_pin || !m_lock);
      else if (op == PROG) ok = m_wel && a < lowest_locked(m_bp);
      else if (op == SE) ok = m_wel && (a / 4096) * 4096 < lowest_locked(m_bp);
      else if (op == BE) ok = m_wel && (a / 65536) * 65536 < lowest_locked(m_bp);
      else if (op == CE) ok = m_wel && m_bp == 0;
      m_vv = (op >= WRSR) ? 1 : 0;
      m_va = ok;
      wel_n = m_wel; aai_n = m_aai;
      if (op == WREN) wel_n = 1;
      if (op == WRDI || ok || aai_top) wel_n = 0;
      if (aai_in && !m_aai_prev) aai_n = 1;
      if (op == WRDI || aai_top) aai_n = 0;
      if (op == WRSR && ok) begin m_bp = (cmd_data >> 2) & 7; m_lock = cmd_data[7]; end
      if (op >= 0) m_arm = (op == WREN || op == EWSR);
      m_wel = wel_n; m_aai = aai_n; m_aai_prev = aai_in;
    end
  end

  task automatic compare();
    logic [7:0] exp_sr;
    exp_sr = {1'(m_lock), 1'(m_aai), 1'b0, 3'(m_bp), 1'(m_wel), busy_in};
    checks++;
    if (status_o !== exp_sr || wel_o !== 1'(m_wel) || verdict_valid !== 1'(m_vv) ||
        verdict_allow !== 1'(m_va)) begin
      errors++;
      $display("FAIL %s: sr=%h wel=%b vv=%b va=%b expected sr=%h wel=%0d vv=%0d va=%0d",
               tag, status_o, wel_o, verdict_valid, verdict_allow, exp_sr, m_wel, m_vv, m_va);
    end
  endtask

  // One clock: check the result of the previous stimulus, then drive the next.
  task automatic cyc(int op, int addr, int data, string t);
    @(negedge clk);
    compare();
    tag = t;
    cmd_valid = (op >= 0);
    cmd_op = 4'(op < 0 ? 0 : op);
    cmd_addr = 19'(addr);
    cmd_data = 8'(data);
  endtask

  task automatic idle(string t);
    cyc(-1, 0, 0, t);
  endtask

  task automatic set_bp(int code, string t);
    cyc(WREN, 0, 0, t);
    cyc(WRSR, 0, code << 2, t);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) idle("R2");
    @(negedge clk); rst_n = 1'b1;
    idle("R2"); idle("R2");
    // R1 busy mirror
    busy_in = 1'b1; idle("R1"); idle("R1"); busy_in = 1'b0; idle("R1");
    // R3/R8 everything locked after reset
    cyc(WREN, 0, 0, "R3"); cyc(PROG, 'h00000, 0, "R3"); idle("R3");
    // R6 arming
    cyc(WRSR, 0, 0, "R6"); idle("R6");
    cyc(EWSR, 0, 0, "R6"); cyc(OTH, 0, 0, "R6"); cyc(WRSR, 0, 0, "R6"); idle("R6");
    cyc(EWSR, 0, 0, "R6"); idle("R6"); cyc(WRSR, 0, 0, "R6"); idle("R6");
    // R4/R7 clear protection with WP high
    set_bp(0, "R4"); idle("R4");
    // R8 WEL zero
    cyc(PROG, 'h100, 0, "R8"); cyc(SE, 'h100, 0, "R8"); idle("R8");
    cyc(WREN, 0, 0, "R7"); cyc(PROG, 'h12345, 0, "R7"); idle("R7");
    // R3/R8 boundaries per code
    set_bp(1, "R3");
    cyc(WREN, 0, 0, "R8"); cyc(PROG, 'h70000, 0, "R8"); cyc(PROG, 'h6FFFF, 0, "R8"); idle("R8");
    set_bp(2, "R3");
    cyc(WREN, 0, 0, "R8"); cyc(SE, 'h60123, 0, "R8"); cyc(SE, 'h5FFFF, 0, "R8"); idle("R8");
    set_bp(3, "R3");
    cyc(WREN, 0, 0, "R8"); cyc(BE, 'h4FFFF, 0, "R8"); cyc(BE, 'h3FFFF, 0, "R8"); idle("R8");
    // R9 chip erase
    cyc(WREN, 0, 0, "R9"); cyc(CE, 0, 0, "R9"); idle("R9");
    set_bp(0, "R9"); cyc(WREN, 0, 0, "R9"); cyc(CE, 0, 0, "R9"); idle("R9");
    set_bp(4, "R3"); cyc(WREN, 0, 0, "R3"); cyc(PROG, 'h00000, 0, "R3"); idle("R3");
    // R5 lock with WP low
    wp_pin = 1'b0;
    cyc(EWSR, 0, 0, "R5"); cyc(WRSR, 0, 'h8C, "R5"); idle("R5");
    // R4 locked, WP low: refused
    cyc(WREN, 0, 0, "R4"); cyc(WRSR, 0, 'h00, "R4"); idle("R4");
    cyc(EWSR, 0, 0, "R4"); cyc(WRSR, 0, 'h00, "R4"); idle("R4");
    // R4 WP high: lock can be cleared
    wp_pin = 1'b1; idle("R4");
    cyc(WREN, 0, 0, "R4"); cyc(WRSR, 0, 'h00, "R4"); idle("R4");
    // R10 aai bit
    aai_in = 1'b1; idle("R10"); idle("R10");
    cyc(WREN, 0, 0, "R10"); cyc(WRDI, 0, 0, "R10"); idle("R10"); idle("R10");
    aai_in = 1'b0; idle("R10"); aai_in = 1'b1; idle("R10");
    // R7 aai_top clears wel and beats WREN
    cyc(WREN, 0, 0, "R7"); idle("R7");
    aai_top = 1'b1; cyc(WREN, 0, 0, "R7"); cyc(-1, 0, 0, "R7"); aai_top = 1'b0; idle("R7");
    aai_in = 1'b0;
    // R11 no verdict for non-write opcodes
    cyc(OTH, 0, 0, "R11"); cyc(EWSR, 0, 0, "R11"); cyc(WRDI, 0, 0, "R11"); idle("R11"); idle("R11");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule